// File: doc/BRIEF.md
# ADC Burst Capture Sequencer

This block is a hardware sequencer for an 8-bit converter with a parallel output. It takes over a job that a small controller would otherwise do in firmware. It drives three active-low control lines on the converter: select, start and output enable. It watches the converter's active-low end-of-conversion line. A start request runs one capture burst of sixteen samples. The samples go into a small register-file RAM, and a one-cycle done pulse marks the end of the burst.

Each burst begins with one throw-away read. That read clears any interrupt left over from earlier activity, and its data is discarded. Each conversion then follows the same steps:

- Select goes low.
- A start strobe of fixed width is issued.
- The sequencer waits for the end-of-conversion line to fall, seen through a synchronizer.
- An output-enable strobe is issued while select is still low, and the byte is captured.
- Select goes high again.

If the converter never answers within a set number of cycles, the burst stops, select is released and a sticky error flag is raised. A separate combinational port lets the rest of the chip read any stored sample by its index within the burst.

Top module: `adc_burst_seq`

## Requirements
- R1: While reset is asserted and directly after it, select, start strobe and output enable are all high (inactive), and done and error are low.
- R2: A start request is accepted only while the sequencer is idle. A request made during a burst changes nothing: that burst still issues exactly sixteen start strobes and one done pulse, and nothing further happens afterwards.
- R3: Each burst begins with exactly one output-enable strobe, issued before any start strobe, with select low. The byte returned by that read is not stored anywhere.
- R4: Every start strobe stays low for exactly WR_W clock cycles (default 2). Select is already low on the cycle before the strobe falls.
- R5: A conversion read starts only after a falling edge of the end-of-conversion line that follows the start strobe. The read stays low for exactly RD_W cycles (default 3), and select is low on the cycle before it. Select is high on the first cycle after every read strobe.
- R6: A complete burst issues exactly sixteen start strobes and seventeen read strobes. It then gives a done pulse exactly one cycle long, and error stays low.
- R7: The sample from conversion k (k = 0..15) is stored at absolute RAM address 0x20 + k, so the burst fills addresses 0x20 through 0x2F in ascending order.
- R8: If the end-of-conversion line does not fall within TMO_CYC cycles of waiting, the burst aborts. Select returns high, no more strobes are issued, error goes high and done does not pulse. Samples stored before the abort are kept, and error clears on the cycle after the next accepted start.
- R9: The read port returns, combinationally, the sample stored at address 0x20 plus its 4-bit index input.
- R10: The start strobe and the output enable are never low together, and neither is ever low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start_i | input | 1 | Burst request, accepted only while idle |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data_i | input | 8 | Converter parallel data |
| adc_sel_n_o | output | 1 | Converter select, active low |
| adc_conv_n_o | output | 1 | Converter start strobe, active low |
| adc_oe_n_o | output | 1 | Converter output enable, active low |
| done_o | output | 1 | One-cycle pulse after the sixteenth sample is stored |
| err_o | output | 1 | Sticky timeout flag, cleared when the next burst is accepted |
| rd_idx_i | input | 4 | Sample index for the read port |
| rd_data_o | output | 8 | Sample at address 0x20 + rd_idx_i |

## Verification
The hardest situation to reach is a timeout in the middle of a burst, because a correct converter always answers. The bench's converter model has a mute threshold: conversions at or beyond a chosen index never pull the end-of-conversion line low. This leaves the sequencer waiting in the sixth conversion until its timer expires. A follow-up burst then shows that the error flag clears and that capture resumes. A stale interrupt is the other hard case. The model starts a burst with its end-of-conversion line already low, so a missing throw-away read would show up as a burst that never finishes.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

  // Sequencer states: D* = discard read phase, C* = conversion phase
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_DSEL  = 4'd1,
    ST_DRD   = 4'd2,
    ST_DREL  = 4'd3,
    ST_CSEL  = 4'd4,
    ST_CCONV = 4'd5,
    ST_CWAIT = 4'd6,
    ST_CRD   = 4'd7,
    ST_CREL  = 4'd8
  } seq_st_e;

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_n_i,
  output logic fall_o
);

  logic s1_q, s2_q, prev_q;

  // Two-flop synchronizer plus one history stage; idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= eoc_n_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall_o = prev_q & ~s2_q;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_sample_ram.sv
module adc_sample_ram #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DW-1:0]     rd_data_o
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we_i && (wr_addr_i == ADDR_W'(BASE_ADDR + g));
    always_ff @(posedge clk) begin
      if (hit) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int DW        = 8,
  parameter int NSAMP     = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32,
  parameter int WR_W      = 2,
  parameter int RD_W      = 3,
  parameter int TMO_CYC   = 4096,
  localparam int IDX_W    = $clog2(NSAMP),
  localparam int REM_W    = $clog2(NSAMP + 1),
  localparam int TMR_W    = $clog2(TMO_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             adc_eoc_n_i,
  input  logic [DW-1:0]    adc_data_i,
  output logic             adc_sel_n_o,
  output logic             adc_conv_n_o,
  output logic             adc_oe_n_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  import adc_burst_pkg::*;

  seq_st_e           st_q, st_d;
  logic [IDX_W-1:0]  ptr_q;
  logic [REM_W-1:0]  rem_q;
  logic              err_q, done_q;

  logic              eoc_fall;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;

  logic ptr_en, ptr_clr, rem_dec, rem_ld, err_set, err_clr, done_d;

  adc_eoc_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoc_n_i (adc_eoc_n_i),
    .fall_o  (eoc_fall)
  );

  adc_seq_timer #(.CW(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign ram_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(ptr_q);

  adc_sample_ram #(
    .DW(DW), .DEPTH(NSAMP), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ram (
    .clk       (clk),
    .we_i      (ram_we),
    .wr_addr_i (ram_addr),
    .wr_data_i (adc_data_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    ram_we  = 1'b0;
    ptr_en  = 1'b0;
    ptr_clr = 1'b0;
    rem_dec = 1'b0;
    rem_ld  = 1'b0;
    err_set = 1'b0;
    err_clr = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_DSEL;
        ptr_clr = 1'b1;
        rem_ld  = 1'b1;
        err_clr = 1'b1;
      end
      ST_DSEL:  st_d = ST_DRD;
      ST_DRD:   if (tmr_zero) st_d = ST_DREL;
      ST_DREL:  st_d = ST_CSEL;
      ST_CSEL:  st_d = ST_CCONV;
      ST_CCONV: if (tmr_zero) st_d = ST_CWAIT;
      ST_CWAIT: begin
        if (eoc_fall) begin
          st_d = ST_CRD;
        end else if (tmr_zero) begin
          st_d    = ST_IDLE;
          err_set = 1'b1;
        end
      end
      ST_CRD: if (tmr_zero) begin
        ram_we  = 1'b1;
        ptr_en  = 1'b1;
        rem_dec = 1'b1;
        st_d    = ST_CREL;
      end
      ST_CREL: begin
        if (rem_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_CSEL;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Timer reload on every state change; width set by the state entered
  always_comb begin
    tmr_load = (st_d != st_q);
    unique case (st_d)
      ST_DRD, ST_CRD: tmr_val = TMR_W'(RD_W - 1);
      ST_CCONV:       tmr_val = TMR_W'(WR_W - 1);
      ST_CWAIT:       tmr_val = TMR_W'(TMO_CYC - 1);
      default:        tmr_val = '0;
    endcase
  end

  // State and counter registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (ptr_clr)     ptr_q <= '0;
      else if (ptr_en) ptr_q <= ptr_q + IDX_W'(1);
      if (rem_ld)       rem_q <= REM_W'(NSAMP);
      else if (rem_dec) rem_q <= rem_q - REM_W'(1);
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  // Pin decode from the registered state
  assign adc_sel_n_o  = (st_q == ST_IDLE) || (st_q == ST_DREL) || (st_q == ST_CREL);
  assign adc_conv_n_o = (st_q != ST_CCONV);
  assign adc_oe_n_o   = !((st_q == ST_DRD) || (st_q == ST_CRD));
  assign done_o       = done_q;
  assign err_o        = err_q;

endmodule

// File: rtl/adc_burst_chk.sv
module adc_burst_chk
  import adc_burst_pkg::*;
#(
  parameter int WR_W = 2,
  parameter int RD_W = 3
) (
  input logic    clk,
  input logic    rst_n,
  input logic    sel_n,
  input logic    conv_n,
  input logic    oe_n,
  input logic    done,
  input logic    err,
  input logic    eoc_fall,
  input seq_st_e st
);

  logic [15:0] conv_len_q, oe_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_len_q <= '0;
      oe_len_q   <= '0;
    end else begin
      conv_len_q <= conv_n ? 16'd0 : conv_len_q + 16'd1;
      oe_len_q   <= oe_n   ? 16'd0 : oe_len_q + 16'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> (sel_n && conv_n && oe_n && !done));

  p_conv_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> !$past(sel_n));

  p_conv_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> (conv_len_q == 16'(WR_W)));

  p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (oe_len_q == 16'(RD_W)));

  p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> sel_n);

  p_read_after_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oe_n) && st == ST_CRD) |-> $past(eoc_fall));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!conv_n && !oe_n));

  p_strobe_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_n || !oe_n) |-> !sel_n);

endmodule

bind adc_burst_seq adc_burst_chk #(.WR_W(WR_W), .RD_W(RD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (adc_sel_n_o),
  .conv_n   (adc_conv_n_o),
  .oe_n     (adc_oe_n_o),
  .done     (done_o),
  .err      (err_o),
  .eoc_fall (eoc_fall),
  .st       (st_q)
);

// File: tb/test_adc_burst_seq.sv
`timescale 1ns/1ps
module test_adc_burst_seq;
  localparam int WR_W = 2;
  localparam int RD_W = 3;
  localparam int TMO  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       eoc_n = 1'b1;
  logic [7:0] adc_data;
  logic       sel_n, conv_n, oe_n, done, err;
  logic [3:0] rd_idx = 4'd0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;

  // converter model and monitor state
  logic [7:0] cur_val = 8'hEE;
  int stub_lat = 5, mute_after = 99, lat = 0, pend_idx = 0;
  int conv_pulses = 0, oe_pulses = 0, done_cnt = 0;
  int bad_excl = 0, bad_setup = 0, bad_conv = 0, bad_oe = 0, bad_rel = 0, bad_order = 0;
  int conv_len = 0, oe_len = 0;
  logic p_sel = 1'b1, p_conv = 1'b1, p_oe = 1'b1;

  always #5 clk = ~clk;

  assign adc_data = (!sel_n && !oe_n) ? cur_val : 8'h00;

  adc_burst_seq #(.WR_W(WR_W), .RD_W(RD_W), .TMO_CYC(TMO)) i_adc_burst_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .adc_eoc_n_i(eoc_n),
    .adc_data_i(adc_data), .adc_sel_n_o(sel_n), .adc_conv_n_o(conv_n),
    .adc_oe_n_o(oe_n), .done_o(done), .err_o(err),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] sample_of(int k);
    return 8'(8'h31 + k * 8'h1D);
  endfunction

  // Behavioural converter and protocol monitor, evaluated on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!conv_n && !oe_n) bad_excl++;
      if ((!conv_n || !oe_n) && sel_n) bad_excl++;
      if (!conv_n && p_conv && p_sel) bad_setup++;
      if (!oe_n && p_oe) begin
        if (p_sel) bad_setup++;
        oe_pulses++;
        if (conv_pulses > 0 && eoc_n) bad_order++;
      end
      if (!conv_n) conv_len++;
      else if (!p_conv) begin
        if (conv_len != WR_W) bad_conv++;
        conv_len = 0;
        conv_pulses++;
        if (conv_pulses - 1 < mute_after) begin
          lat = stub_lat;
          pend_idx = conv_pulses - 1;
        end
      end
      if (!oe_n) oe_len++;
      else if (!p_oe) begin
        if (oe_len != RD_W) bad_oe++;
        if (!sel_n) bad_rel++;
        oe_len = 0;
      end
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          eoc_n = 1'b0;
          cur_val = sample_of(pend_idx);
        end
      end
      if (!sel_n && !oe_n) eoc_n = 1'b1;
      if (done) done_cnt++;
    end
    p_sel = sel_n; p_conv = conv_n; p_oe = oe_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon(input bit stale, input int latency, input int mute);
    @(negedge clk);
    conv_pulses = 0; oe_pulses = 0; done_cnt = 0;
    bad_excl = 0; bad_setup = 0; bad_conv = 0; bad_oe = 0; bad_rel = 0; bad_order = 0;
    stub_lat = latency; mute_after = mute; lat = 0;
    cur_val = 8'hEE;
    eoc_n = stale ? 1'b0 : 1'b1;
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  task automatic check_ram(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(rd_data == sample_of(i), req, rd_data, sample_of(i));
    end
  endtask

  task automatic check_protocol;
    chk(bad_setup == 0, "R4 select setup before strobe", bad_setup, 0);
    chk(bad_conv == 0, "R4 start strobe width", bad_conv, 0);
    chk(bad_oe == 0, "R5 read strobe width", bad_oe, 0);
    chk(bad_order == 0, "R5 read only after end-of-conversion", bad_order, 0);
    chk(bad_rel == 0, "R5 select high after read", bad_rel, 0);
    chk(bad_excl == 0, "R10 strobe exclusivity", bad_excl, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_n && conv_n && oe_n, "R1 pins idle in reset", {sel_n, conv_n, oe_n}, 7);
    chk(!done && !err, "R1 flags low in reset", {done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sel_n && conv_n && oe_n && !done && !err, "R1 idle after reset",
        {sel_n, conv_n, oe_n, done, err}, 28);
  endtask

  task automatic t_burst(input bit stale, input int latency);
    clr_mon(stale, latency, 99);
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
    chk(!err, "R6 no error on full burst", err, 0);
    chk(conv_pulses == 16, "R6 sixteen start strobes", conv_pulses, 16);
    chk(oe_pulses == 17, "R3 one discard read plus sixteen", oe_pulses, 17);
    chk(sel_n, "R5 select high at burst end", sel_n, 1);
    check_protocol();
    check_ram(16, "R7 ordered storage at 0x20+k / R9 read port");
    rd_idx = 4'd0; #1;
    chk(rd_data != 8'hEE, "R3 discard data not stored", rd_data, 0);
  endtask

  task automatic t_start_ignored;
    clr_mon(1'b0, 4, 99);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_end();
    repeat (30) @(negedge clk);
    chk(conv_pulses == 16, "R2 mid-burst start ignored (strobes)", conv_pulses, 16);
    chk(done_cnt == 1, "R2 mid-burst start ignored (done)", done_cnt, 1);
    chk(sel_n, "R2 idle after burst", sel_n, 1);
    check_ram(16, "R2 data intact");
  endtask

  task automatic t_timeout;
    clr_mon(1'b0, 5, 5);
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(err, "R8 error raised on timeout", err, 1);
    chk(done_cnt == 0, "R8 no done on abort", done_cnt, 0);
    chk(conv_pulses == 6, "R8 abort on sixth conversion", conv_pulses, 6);
    chk(sel_n, "R8 select released on abort", sel_n, 1);
    repeat (30) @(negedge clk);
    chk(conv_pulses == 6 && oe_pulses == 6, "R8 no strobes after abort", conv_pulses, 6);
    chk(err, "R8 error sticky while idle", err, 1);
    check_ram(5, "R8 earlier samples kept");
    check_protocol();
    clr_mon(1'b0, 3, 99);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!err, "R8 error cleared by next start", err, 0);
    wait_end();
    @(negedge clk);
    chk(done_cnt == 1 && conv_pulses == 16, "R8 recovery burst completes", done_cnt, 1);
    check_ram(16, "R8 recovery data");
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(1'b0, 5);
    t_burst(1'b1, 1);
    t_burst(1'b0, 20);
    t_start_ignored();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule